// File: doc/BRIEF.md
# Handshake Progress Tracker with Change Interrupt

The tracker follows a modem call-setup handshake and publishes its progress as two packed status bytes: one for the receive side and one for the transmit side. Each byte carries a phase code in its upper three bits and a state number within that phase in its lower five bits.

During the opening call-setup phase, each side steps its own small state machine. One-cycle pulses from external tone and menu detectors drive these steps. A shared mode input selects whether the local end originates or answers the call, and the two modes follow different detection sequences. Later phases are entered through a per-side phase-advance input, which loads a new phase code and resets the state number to 0.

Whenever a status byte takes a new value, a sticky change flag is raised for that byte. The host clears the flag by writing 1 to it. An interrupt line is asserted while any flag is pending and its mask bit is enabled.

Top module: `hspt_top`

## Requirements
- R1: After reset, both status bytes read 0x00, both pending flags are 0 and the interrupt is low.
- R2: In each status byte, bits 7:5 hold the phase code and bits 4:0 hold the state number. The phase codes are:
  - 0: call-setup phase.
  - 1 to 3: phases two to four.
  - 4: rate renegotiation within phase four.
- R3: With `answerMode`=0 (originate) and phase 0, a detector vector has five bits:
  - bit 0: answer tone.
  - bit 1: joint menu.
  - bit 2: call indicator.
  - bit 3: call menu.
  - bit 4: call joint.

  An answer-tone pulse moves state 0 to 1, and a joint-menu pulse moves state 1 to 2. State 2 is final. Each step shows in the status byte one clock edge after the pulse.
- R4: With `answerMode`=1 (answer) and phase 0, the steps are as follows. State 2 moves to 3 on a call-joint pulse, and state 3 is final.
  - State 0 moves to 1 on a call-indicator pulse.
  - State 1 moves to 2 on a call-menu pulse.
- R5: In answer mode, a call-menu pulse in state 0 moves straight to state 2. This also applies when a call-indicator pulse comes in the same cycle.
- R6: A detector pulse that is not the one the current state expects leaves the status byte unchanged and raises no pending flag.
- R7: A phase-advance request with a code from 0 to 4 loads that code into bits 7:5 and 0 into bits 4:0. It takes priority over a detector pulse in the same cycle. While the phase code is not 0, detector pulses have no effect.
- R8: A phase-advance request with a code from 5 to 7 is ignored.
- R9: A side's pending flag is set on the same edge that its status byte changes value. An update that writes the value the byte already holds sets no flag.
- R10: Writing 1 to a bit of `pendClr` clears that pending flag. If a change of the same byte falls in the same cycle, the flag stays set.
- R11: `irq` is the OR, over both sides, of each pending flag ANDed with its mask bit. Bit 0 of the mask is the receive side and bit 1 is the transmit side. Masking does not alter the pending flags.
- R12: The receive and transmit sides step independently. Stimulus on one side never changes the other side's byte or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| answerMode | input | 1 | 0 = originate, 1 = answer |
| rxDet | input | 5 | Receive-side detector pulses (bit map in R3) |
| txDet | input | 5 | Transmit-side detector pulses |
| rxAdvValid | input | 1 | Receive-side phase-advance request |
| rxAdvPhase | input | 3 | Receive-side phase code to load |
| txAdvValid | input | 1 | Transmit-side phase-advance request |
| txAdvPhase | input | 3 | Transmit-side phase code to load |
| intMask | input | 2 | Interrupt enables, bit 0 receive, bit 1 transmit |
| pendClr | input | 2 | Write-1-to-clear strobes for the pending flags |
| rxStatus | output | 8 | Receive-side status byte |
| txStatus | output | 8 | Transmit-side status byte |
| pending | output | 2 | Change-pending flags, bit 0 receive, bit 1 transmit |
| irq | output | 1 | Masked change interrupt |

## Verification
Two functions can fall in the same cycle: the host's write-1 clear of a pending flag and a new change of the same status byte. The bench provokes this by raising the receive flag, then pulsing a matching detector in the same cycle as the clear. One edge later it expects the new state value with the flag still set. A clear issued alone afterwards must then drop the flag. A second collision, a phase-advance request arriving with a matching detector pulse, is judged by the loaded byte showing the requested phase with state 0.

// File: rtl/hspt_pkg.sv
package hspt_pkg;

  localparam int PHASE_W = 3;
  localparam int STATE_W = 5;
  localparam int STAT_W  = PHASE_W + STATE_W;
  localparam int DET_W   = 5;
  localparam int SIDES   = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_CALLSETUP = 3'd0,
    PH_PROBE     = 3'd1,
    PH_EQTRAIN   = 3'd2,
    PH_FINAL     = 3'd3,
    PH_RENEG     = 3'd4
  } phase_e;

  // detector vector bit positions
  localparam int DET_ANSTONE = 0;
  localparam int DET_JMENU   = 1;
  localparam int DET_CIND    = 2;
  localparam int DET_CMENU   = 3;
  localparam int DET_CJOINT  = 4;

  // call-setup state numbers
  localparam logic [STATE_W-1:0] ST_IDLE  = 5'd0;
  localparam logic [STATE_W-1:0] ST_FIRST = 5'd1;
  localparam logic [STATE_W-1:0] ST_MENU  = 5'd2;
  localparam logic [STATE_W-1:0] ST_DONE  = 5'd3;

  typedef struct packed {
    logic               load;
    logic [PHASE_W-1:0] phase;
    logic [STATE_W-1:0] state;
  } updStrobe_t;

endpackage

// File: rtl/hspt_ctrl.sv
module hspt_ctrl
  import hspt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               answerMode,
  input  logic [DET_W-1:0]   det,
  input  logic               advValid,
  input  logic [PHASE_W-1:0] advPhase,
  input  logic [STAT_W-1:0]  curStatus,
  output updStrobe_t         upd
);

  logic [PHASE_W-1:0] curPhase;
  logic [STATE_W-1:0] curState;
  logic               advLegal;

  assign curPhase = curStatus[STAT_W-1:STATE_W];
  assign curState = curStatus[STATE_W-1:0];
  assign advLegal = advValid && (advPhase <= PH_RENEG);

  always_comb begin
    upd.load  = 1'b0;
    upd.phase = curPhase;
    upd.state = curState;
    if (advLegal) begin
      upd.load  = 1'b1;
      upd.phase = advPhase;
      upd.state = ST_IDLE;
    end else if (curPhase == PH_CALLSETUP) begin
      if (!answerMode) begin
        case (curState)
          ST_IDLE:  if (det[DET_ANSTONE]) begin upd.load = 1'b1; upd.state = ST_FIRST; end
          ST_FIRST: if (det[DET_JMENU])   begin upd.load = 1'b1; upd.state = ST_MENU;  end
          default: ;
        endcase
      end else begin
        case (curState)
          ST_IDLE: begin
            if (det[DET_CMENU]) begin
              upd.load = 1'b1; upd.state = ST_MENU;
            end else if (det[DET_CIND]) begin
              upd.load = 1'b1; upd.state = ST_FIRST;
            end
          end
          ST_FIRST: if (det[DET_CMENU])  begin upd.load = 1'b1; upd.state = ST_MENU; end
          ST_MENU:  if (det[DET_CJOINT]) begin upd.load = 1'b1; upd.state = ST_DONE; end
          default: ;
        endcase
      end
    end
  end

  // R7: a legal advance shows up one edge later with state cleared
  a_r7_adv_loads: assert property (@(posedge clk) disable iff (!rstN)
    advLegal |=> (curStatus[STATE_W-1:0] == ST_IDLE) &&
                 (curStatus[STAT_W-1:STATE_W] == $past(advPhase)));

  // R8: an illegal code outside call setup leaves the byte alone
  a_r8_bad_code: assert property (@(posedge clk) disable iff (!rstN)
    (advValid && !advLegal && curPhase != PH_CALLSETUP) |=> $stable(curStatus));

  // R6: call-setup progress only moves forward
  a_r6_forward_only: assert property (@(posedge clk) disable iff (!rstN)
    ($past(curPhase) == PH_CALLSETUP && !$past(advValid) && curStatus != $past(curStatus))
      |-> curState > $past(curState));

endmodule

// File: rtl/hspt_dpath.sv
module hspt_dpath
  import hspt_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  updStrobe_t                    upd [SIDES],
  input  logic [SIDES-1:0]              mask,
  input  logic [SIDES-1:0]              clr,
  output logic [SIDES-1:0][STAT_W-1:0]  status,
  output logic [SIDES-1:0]              pend,
  output logic                          irq
);

  logic [SIDES-1:0][STAT_W-1:0] statusQ;
  logic [SIDES-1:0]             pendQ;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic [STAT_W-1:0] nextByte;
    logic              changed;

    assign nextByte = {upd[s].phase, upd[s].state};
    assign changed  = upd[s].load && (nextByte != statusQ[s]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statusQ[s] <= '0;
        pendQ[s]   <= 1'b0;
      end else begin
        if (upd[s].load) statusQ[s] <= nextByte;
        pendQ[s] <= changed | (pendQ[s] & ~clr[s]);
      end
    end

    // R9: every visible change leaves the flag set
    a_r9_change_pends: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[s] != $past(statusQ[s])) |-> pendQ[s]);

    // R10: a flag only drops after a clear strobe
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
      ($past(pendQ[s]) && !$past(clr[s])) |-> pendQ[s]);

    // R2: phase field never holds an undefined code
    a_r2_phase_legal: assert property (@(posedge clk) disable iff (!rstN)
      statusQ[s][STAT_W-1:STATE_W] <= PH_RENEG);
  end

  assign status = statusQ;
  assign pend   = pendQ;
  assign irq    = |(pendQ & mask);

  // R11: no interrupt without a pending flag
  a_r11_irq_needs_pend: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (pendQ != '0));

endmodule

// File: rtl/hspt_top.sv
module hspt_top
  import hspt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               answerMode,
  input  logic [4:0]         rxDet,
  input  logic [4:0]         txDet,
  input  logic               rxAdvValid,
  input  logic [2:0]         rxAdvPhase,
  input  logic               txAdvValid,
  input  logic [2:0]         txAdvPhase,
  input  logic [1:0]         intMask,
  input  logic [1:0]         pendClr,
  output logic [7:0]         rxStatus,
  output logic [7:0]         txStatus,
  output logic [1:0]         pending,
  output logic               irq
);

  logic [SIDES-1:0][DET_W-1:0]   detArr;
  logic [SIDES-1:0]              advValidArr;
  logic [SIDES-1:0][PHASE_W-1:0] advPhaseArr;
  logic [SIDES-1:0][STAT_W-1:0]  statusArr;
  updStrobe_t                    updArr [SIDES];

  assign detArr      = {txDet, rxDet};
  assign advValidArr = {txAdvValid, rxAdvValid};
  assign advPhaseArr = {txAdvPhase, rxAdvPhase};

  for (genvar s = 0; s < SIDES; s++) begin : g_ctrl
    hspt_ctrl u_ctrl (
      .clk        (clk),
      .rstN       (rstN),
      .answerMode (answerMode),
      .det        (detArr[s]),
      .advValid   (advValidArr[s]),
      .advPhase   (advPhaseArr[s]),
      .curStatus  (statusArr[s]),
      .upd        (updArr[s])
    );
  end

  hspt_dpath u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .upd    (updArr),
    .mask   (intMask),
    .clr    (pendClr),
    .status (statusArr),
    .pend   (pending),
    .irq    (irq)
  );

  assign rxStatus = statusArr[0];
  assign txStatus = statusArr[1];

endmodule

// File: tb/test_hspt_top.sv
`timescale 1ns/1ps
module test_hspt_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       answerMode;
  logic [4:0] rxDet, txDet;
  logic       rxAdvValid, txAdvValid;
  logic [2:0] rxAdvPhase, txAdvPhase;
  logic [1:0] intMask, pendClr;
  logic [7:0] rxStatus, txStatus;
  logic [1:0] pending;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // detector bits: 0 answer tone, 1 joint menu, 2 call indicator, 3 call menu, 4 call joint
  localparam logic [4:0] ANS = 5'b00001, JM = 5'b00010, CI = 5'b00100, CM = 5'b01000, CJ = 5'b10000;

  always #2.5 clk = ~clk;

  hspt_top i_hspt_top (
    .clk(clk), .rstN(rstN), .answerMode(answerMode),
    .rxDet(rxDet), .txDet(txDet),
    .rxAdvValid(rxAdvValid), .rxAdvPhase(rxAdvPhase),
    .txAdvValid(txAdvValid), .txAdvPhase(txAdvPhase),
    .intMask(intMask), .pendClr(pendClr),
    .rxStatus(rxStatus), .txStatus(txStatus),
    .pending(pending), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; rxDet = '0; txDet = '0; rxAdvValid = 0; txAdvValid = 0;
    rxAdvPhase = '0; txAdvPhase = '0; pendClr = '0; intMask = 2'b11;
    step(); step();
    rstN = 1'b1;
    step();
  endtask

  task automatic pulseRx(input logic [4:0] d);
    rxDet = d; step(); rxDet = '0;
  endtask

  task automatic pulseTx(input logic [4:0] d);
    txDet = d; step(); txDet = '0;
  endtask

  task automatic clearAll();
    pendClr = 2'b11; step(); pendClr = '0;
  endtask

  task automatic advRx(input logic [2:0] ph);
    rxAdvValid = 1; rxAdvPhase = ph; step(); rxAdvValid = 0;
  endtask

  task automatic t_reset();
    answerMode = 0; doReset();
    chk("R1", "rxStatus", rxStatus, 8'h00);
    chk("R1", "txStatus", txStatus, 8'h00);
    chk("R1", "pending", pending, 2'b00);
    chk("R1", "irq", irq, 1'b0);
  endtask

  task automatic t_originate();
    answerMode = 0; doReset();
    pulseRx(JM);
    chk("R6", "early joint menu ignored", rxStatus, 8'h00);
    chk("R6", "no pending on ignored pulse", pending, 2'b00);
    pulseRx(ANS);
    chk("R3", "answer tone -> state 1", rxStatus, 8'h01);
    chk("R9", "pending set with change", pending, 2'b01);
    chk("R11", "irq with mask on", irq, 1'b1);
    chk("R12", "tx side untouched", txStatus, 8'h00);
    clearAll();
    chk("R10", "pending cleared", pending, 2'b00);
    pulseRx(JM);
    chk("R3", "joint menu -> state 2", rxStatus, 8'h02);
    pulseRx(ANS | JM | CM | CJ);
    chk("R3", "state 2 final", rxStatus, 8'h02);
  endtask

  task automatic t_answer();
    answerMode = 1; doReset();
    pulseTx(ANS);
    chk("R6", "answer tone ignored in answer mode", txStatus, 8'h00);
    pulseTx(CI);
    chk("R4", "call indicator -> 1", txStatus, 8'h01);
    chk("R12", "tx pending only", pending, 2'b10);
    pulseTx(CJ);
    chk("R6", "call joint early ignored", txStatus, 8'h01);
    pulseTx(CM);
    chk("R4", "call menu -> 2", txStatus, 8'h02);
    pulseTx(CJ);
    chk("R4", "call joint -> 3", txStatus, 8'h03);
    pulseTx(5'b11111);
    chk("R4", "state 3 final", txStatus, 8'h03);
    chk("R12", "rx side untouched", rxStatus, 8'h00);
  endtask

  task automatic t_skip();
    answerMode = 1; doReset();
    pulseRx(CI | CM);
    chk("R5", "call menu wins from state 0", rxStatus, 8'h02);
    doReset();
    pulseRx(CM);
    chk("R5", "call menu alone from state 0", rxStatus, 8'h02);
  endtask

  task automatic t_advance();
    answerMode = 0; doReset();
    rxDet = ANS; advRx(3'd3); rxDet = '0;
    chk("R7", "advance beats detector", rxStatus, 8'h60);
    chk("R2", "phase field bits 7:5", {29'd0, rxStatus[7:5]}, 32'd3);
    clearAll();
    pulseRx(ANS);
    chk("R7", "detector ignored outside phase 0", rxStatus, 8'h60);
    advRx(3'd4);
    chk("R2", "renegotiation code 4", rxStatus, 8'h80);
    clearAll();
    advRx(3'd5);
    chk("R8", "code 5 ignored", rxStatus, 8'h80);
    advRx(3'd7);
    chk("R8", "code 7 ignored", rxStatus, 8'h80);
    chk("R8", "no pending from illegal code", pending, 2'b00);
    advRx(3'd4);
    chk("R9", "same value sets no pending", pending, 2'b00);
    advRx(3'd0);
    chk("R7", "back to phase 0", rxStatus, 8'h00);
    pulseRx(ANS);
    chk("R3", "stepping resumes", rxStatus, 8'h01);
  endtask

  task automatic t_clearRace();
    answerMode = 0; doReset();
    pulseRx(ANS);
    chk("R9", "flag raised", pending[0], 1'b1);
    pendClr = 2'b01; rxDet = JM; step(); pendClr = '0; rxDet = '0;
    chk("R10", "set wins over clear", pending[0], 1'b1);
    chk("R10", "byte advanced", rxStatus, 8'h02);
    pendClr = 2'b01; step(); pendClr = '0;
    chk("R10", "clear alone drops flag", pending[0], 1'b0);
  endtask

  task automatic t_mask();
    answerMode = 0; doReset();
    intMask = 2'b00;
    pulseRx(ANS);
    chk("R11", "irq masked", irq, 1'b0);
    chk("R11", "pending unaffected by mask", pending, 2'b01);
    intMask = 2'b10; #1;
    chk("R11", "tx mask does not pass rx flag", irq, 1'b0);
    intMask = 2'b01; #1;
    chk("R11", "rx mask passes rx flag", irq, 1'b1);
    intMask = 2'b10;
    pulseTx(ANS);
    chk("R11", "tx flag through tx mask", irq, 1'b1);
    pendClr = 2'b10; step(); pendClr = '0;
    chk("R11", "irq drops after tx clear", irq, 1'b0);
    chk("R12", "rx flag kept", pending, 2'b01);
  endtask

  initial begin
    rstN = 1'b0; answerMode = 0; rxDet = '0; txDet = '0;
    rxAdvValid = 0; txAdvValid = 0; rxAdvPhase = '0; txAdvPhase = '0;
    intMask = '0; pendClr = '0;
    t_reset();
    t_originate();
    t_answer();
    t_skip();
    t_advance();
    t_clearRace();
    t_mask();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule